// File: doc/BRIEF.md
# Dual Thermometer Differencing Quantizer Backend

This block is the digital back end of a differential flash quantizer built from two single-ended comparator banks. One bank watches the positive leg of a differential signal. The other bank watches the negative leg. Each bank hands the block a thermometer word.

The block counts the ones in each word to get a binary level for that leg. It centres each level about mid-scale. It then subtracts the negative-leg level from the positive-leg level. Any shift that the two legs share, such as common-mode offset or noise, appears equally in both counts and cancels in the subtraction. What remains is a signed difference code with 65 possible values.

Both thermometer words are captured on the same clock edge. The difference is registered on the following edge, together with a valid flag and a separate parity flag. A downstream requantizer uses the parity flag to decide whether it has to act.

Top module: `dtq_diff_quantizer`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next clock edge sets `diff_code` to 0, `diff_odd` to 0 and `diff_valid` to 0.
- R2: After reset is released, `diff_valid` is 0 after the first clock edge and 1 from the second clock edge onward.
- R3: Inputs sampled at clock edge k appear on `diff_code` after edge k+1, which is two register stages and one cycle of latency.
- R4: Each leg's level is the number of 1 bits anywhere in its 32-bit thermometer word. Non-monotonic (bubbled) words therefore give a count between 0 and 32 and never an out-of-range level.
- R5: `diff_code` is a 7-bit two's-complement value equal to (ones(pos) − 16) − (ones(neg) − 16). It spans −32 to +32.
- R6: Adding the same number of ones to both legs leaves `diff_code` unchanged, which is how common-mode shift is rejected.
- R7: When the two leg counts sum to 32 (no common-mode component), `diff_code` is even and `diff_odd` is 0.
- R8: `diff_odd` is 1 exactly when `diff_code` is odd, that is, it equals bit 0 of `diff_code`.
- R9: An all-ones positive word with an all-zeros negative word gives +32 (7'b0100000). The reverse gives −32 (7'b1100000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| thermo_pos | input | 32 | Thermometer word from the positive-leg comparator bank |
| thermo_neg | input | 32 | Thermometer word from the negative-leg comparator bank |
| diff_code | output | 7 | Signed centred difference, two's complement |
| diff_odd | output | 1 | Parity of the difference, 1 when it is odd |
| diff_valid | output | 1 | High once `diff_code` holds a difference of sampled inputs |

## Verification
The stimulus patterns, and what each one distinguishes:

- **Clean monotonic thermometer sweeps** over every level on both legs establish the basic subtraction and the sign convention.
- **Mirrored pairs whose counts sum to 32** model a purely differential input. They must give only even codes, which separates a correct subtractor from one that drops or shifts a bit.
- **Pairs raised together by a common offset** show that the shared component cancels.
- **Bubbled and scattered words** show that the encoders count ones rather than searching for a transition.
- **Full-scale extremes** and a **mid-run reset** pin down the ends of the signed range, the two-cycle latency and the valid flag.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

  // Number of bits needed to hold a population count of a w-bit word.
  function automatic int dtq_count_width(input int w);
    return $clog2(w + 1);
  endfunction

  // Mid-scale level of a single-ended bank with w comparators.
  function automatic int dtq_mid_level(input int w);
    return w / 2;
  endfunction

endpackage

// File: rtl/dtq_ones_count.sv
// Counts ones anywhere in a thermometer word. Bubbles are tolerated by
// construction of a population count.
module dtq_ones_count #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 6
) (
  input  logic [WIDTH-1:0] word,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count = count + CNT_W'(word[i]);
    end
  end
endmodule

// File: rtl/dtq_centre.sv
// Shifts an unsigned level so that mid-scale maps to zero.
module dtq_centre #(
  parameter int CNT_W = 6,
  parameter int MID   = 16
) (
  input  logic [CNT_W-1:0]        level,
  output logic signed [CNT_W:0]   centred
);
  localparam logic signed [CNT_W:0] MID_S = (CNT_W+1)'(MID);

  always_comb begin
    centred = $signed({1'b0, level}) - MID_S;
  end
endmodule

// File: rtl/dtq_diff_quantizer.sv
module dtq_diff_quantizer #(
  parameter int LEVELS = 33
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LEVELS-2:0]         thermo_pos,
  input  logic [LEVELS-2:0]         thermo_neg,
  output logic signed [dtq_pkg::dtq_count_width(LEVELS-1):0] diff_code,
  output logic                      diff_odd,
  output logic                      diff_valid
);
  import dtq_pkg::*;

  localparam int THERMO_W = LEVELS - 1;
  localparam int CNT_W    = dtq_count_width(THERMO_W);
  localparam int MID      = dtq_mid_level(THERMO_W);
  localparam int DIFF_W   = CNT_W + 1;

  // Stage 1: capture both legs on the same edge.
  logic [THERMO_W-1:0] word_q [2];
  logic                s1_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q[0] <= '0;
      word_q[1] <= '0;
      s1_valid  <= 1'b0;
    end else begin
      word_q[0] <= thermo_pos;
      word_q[1] <= thermo_neg;
      s1_valid  <= 1'b1;
    end
  end

  // Per-leg encode and centre (index 0 = positive leg, 1 = negative leg).
  logic [CNT_W-1:0]         leg_cnt [2];
  logic signed [CNT_W:0]    leg_ctr [2];

  for (genvar g = 0; g < 2; g++) begin : g_leg
    dtq_ones_count #(.WIDTH(THERMO_W), .CNT_W(CNT_W)) u_count (
      .word  (word_q[g]),
      .count (leg_cnt[g])
    );
    dtq_centre #(.CNT_W(CNT_W), .MID(MID)) u_centre (
      .level   (leg_cnt[g]),
      .centred (leg_ctr[g])
    );
  end

  logic signed [DIFF_W-1:0] diff_d;
  logic                     odd_d;

  always_comb begin
    diff_d = leg_ctr[0] - leg_ctr[1];
    odd_d  = leg_cnt[0][0] ^ leg_cnt[1][0];
  end

  // Stage 2: registered difference, parity and valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      diff_code  <= '0;
      diff_odd   <= 1'b0;
      diff_valid <= 1'b0;
    end else begin
      diff_code  <= diff_d;
      diff_odd   <= odd_d;
      diff_valid <= s1_valid;
    end
  end

  // R1: reset clears the output register.
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (diff_code == '0 && !diff_odd && !diff_valid));

  // R2: valid never leads the capture stage.
  a_r2_valid_order: assert property (@(posedge clk) disable iff (rst)
    diff_valid |-> s1_valid);

  // R4: leg counts stay in range whatever the bubbles.
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(leg_cnt[0]) <= THERMO_W) && (int'(leg_cnt[1]) <= THERMO_W));

  // R5: the difference stays within the signed span.
  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    diff_valid |-> (int'(diff_code) >= -THERMO_W && int'(diff_code) <= THERMO_W));

  // R7: counts summing to full scale give an even result.
  a_r7_even_no_cm: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && (int'(leg_cnt[0]) + int'(leg_cnt[1]) == THERMO_W)) |=> !diff_odd);

  // R8: parity flag agrees with the low bit of the difference.
  a_r8_parity: assert property (@(posedge clk) disable iff (rst)
    diff_valid |-> (diff_odd == diff_code[0]));

endmodule

// File: tb/tb_dtq_diff_quantizer.sv
module tb_dtq_diff_quantizer;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [W-1:0]      thermo_pos = '0;
  logic [W-1:0]      thermo_neg = '0;
  logic signed [6:0] diff_code;
  logic              diff_odd;
  logic              diff_valid;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Reference model state: capture stage and output stage.
  int m_s1  = 0;
  bit m_s1v = 1'b0;
  int m_out = 0;
  bit m_outv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtq_diff_quantizer dut (
    .clk        (clk),
    .rst        (rst),
    .thermo_pos (thermo_pos),
    .thermo_neg (thermo_neg),
    .diff_code  (diff_code),
    .diff_odd   (diff_odd),
    .diff_valid (diff_valid)
  );

  function automatic logic [W-1:0] therm(input int k);
    return W'((64'd1 << k) - 64'd1);
  endfunction

  task automatic cycle(input logic [W-1:0] p, input logic [W-1:0] n,
                       input bit r, input string tag);
    thermo_pos = p;
    thermo_neg = n;
    rst        = r;
    @(posedge clk);
    if (r) begin
      m_out = 0; m_outv = 0; m_s1 = 0; m_s1v = 0;
    end else begin
      m_out  = m_s1;
      m_outv = m_s1v;
      m_s1   = ($countones(p) - 16) - ($countones(n) - 16);
      m_s1v  = 1'b1;
    end
    @(negedge clk);
    vectors++;
    if (int'(diff_code) != m_out || diff_valid != m_outv ||
        diff_odd != ((m_out % 2) != 0)) begin
      fails++;
      $display("FAIL %s: diff=%0d valid=%0b odd=%0b expected diff=%0d valid=%0b odd=%0b",
               tag, diff_code, diff_valid, diff_odd, m_out, m_outv, (m_out % 2) != 0);
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    cycle('1, '0, 1'b1, "R1");
    cycle('1, '0, 1'b1, "R1");
    // R2: valid rises on second edge after release
    cycle(therm(20), therm(10), 1'b0, "R2");
    cycle(therm(5), therm(25), 1'b0, "R2");
    // R3 and R5: clean sweeps over every level
    for (int k = 0; k <= W; k++) cycle(therm(k), therm(16), 1'b0, "R5");
    for (int k = 0; k <= W; k++) cycle(therm(16), therm(k), 1'b0, "R3");
    // R7: mirrored pairs, no common mode
    for (int k = 0; k <= W; k++) cycle(therm(k), therm(W - k), 1'b0, "R7");
    // R6: common offset added to both legs
    for (int s = 0; s <= 12; s++) cycle(therm(10 + s), therm(3 + s), 1'b0, "R6");
    // R8: odd differences
    for (int k = 0; k < W; k++) cycle(therm(k + 1), therm(W - k), 1'b0, "R8");
    // R4: bubbled and scattered words
    cycle(32'hA5A5_A5A5, 32'h0000_FFFF, 1'b0, "R4");
    cycle(32'hFFFF_FFFE, 32'h8000_0001, 1'b0, "R4");
    cycle(32'h0F0F_00F7, 32'hFFF0_FF0F, 1'b0, "R4");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = W'(32'h9E37_79B9 * (i + 1));
      b = W'(32'h85EB_CA6B ^ (i * 32'h0101_0111));
      cycle(a, b, 1'b0, "R4");
    end
    // R9: full-scale extremes
    cycle('1, '0, 1'b0, "R9");
    cycle('0, '1, 1'b0, "R9");
    cycle('1, '1, 1'b0, "R9");
    cycle('0, '0, 1'b0, "R9");
    // R1: reset in mid-run, then R2 recovery
    cycle('1, '0, 1'b1, "R1");
    cycle(therm(30), therm(2), 1'b0, "R2");
    cycle(therm(2), therm(30), 1'b0, "R2");
    cycle(therm(9), therm(9), 1'b0, "R3");
    cycle('0, '0, 1'b0, "R3");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule